// File: doc/BRIEF.md
# Pseudo-Random Re-Lock Timer

This block decides when a logic-locked circuit must drop back out of its unlocked mode and which locked state it should land in. It sits beside the key-checking state machine, which drives a single "authenticated" flag. When that flag is seen, the controller samples a free-running LFSR and uses the value as the length of the unlocked window. A counter then measures the window.

When the count reaches the captured length, the controller raises a one-cycle re-lock request. In the same cycle it drives the index of the locked state to re-enter. That index comes from a second sample of the same LFSR. The lock machine answers the request by dropping the authenticated flag. Only after that drop does the controller arm itself for the next authentication.

Because the window length and the landing state are taken from one generator at two different instants, both are hard to predict unless the seed and polynomial are known.

Top module: `relock_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the controller to the POLL state, clears the window counter and the period latch, and reloads the LFSR with the seed `SEED` (default 8'hA5). While reset is held, `relock_req_o` is 0 and `relock_idx_o` is 0.
- R2: The LFSR steps on every clock edge with reset low. Each step shifts it left by one bit, and the new bit 0 is the XOR of a maximal-length tap set; for the default width of 8, that is the XOR of bits 7, 5, 4 and 3. Its value is never zero.
- R3: In POLL, an edge with `auth_i` high captures the current LFSR value as the period P (a value of zero would be replaced by 1). The same edge clears the counter and moves the controller to TIME.
- R4: In TIME, the counter advances by one on each edge. `relock_req_o` stays low for exactly P cycles after the capture edge. It is high in the cycle in which the count equals P, and that cycle begins P edges after the capture edge.
- R5: In the request cycle, `relock_idx_o` equals the low `IDX_W` bits (default 3) of the LFSR value in that cycle. In every other cycle it is 0.
- R6: The request lasts one cycle. On the next edge the controller moves from TIME to DRAIN.
- R7: In DRAIN, a high `auth_i` causes neither a capture nor a request. The edge that sees `auth_i` low returns the controller to POLL, where a new authentication starts a new window.
- R8: Once a window has started, a fall of `auth_i` during TIME neither stops nor restarts it. The request still comes P cycles after the capture edge.
- R9: A reset during TIME cancels the pending request. After reset, no request appears until a new authentication occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| auth_i | input | 1 | Authenticated status from the lock state machine |
| relock_req_o | output | 1 | One-cycle request to fall back into the locked mode |
| relock_idx_o | output | IDX_W | Index of the locked state to enter, valid with the request |

## Verification
A wrong internal state shows at the ports as a request that arrives at the wrong distance from authentication. A corrupted period latch or counter shifts the request by at least one cycle; a counter that never matches removes it entirely. A corrupted LFSR shows twice: first in the length of the next window, and then in the index that comes with its request. Both therefore appear within one window, at most 2^PRNG_W cycles. A control state stuck in TIME or POLL shows as a request longer than one cycle, or as a second window started while the flag was still high.

// File: rtl/relock_pkg.sv
package relock_pkg;

    typedef enum logic [1:0] {
        ST_POLL  = 2'd0,
        ST_TIME  = 2'd1,
        ST_DRAIN = 2'd2
    } relock_state_e;

    // Maximal-length tap masks for a left-shifting Fibonacci LFSR.
    // Bit k-1 of the mask selects register bit k-1 (tap k).
    function automatic logic [15:0] lfsr_taps(input int width);
        logic [15:0] m;
        m = 16'h0000;
        case (width)
            5:  m = 16'h0014;  // 5,3
            6:  m = 16'h0030;  // 6,5
            7:  m = 16'h0060;  // 7,6
            8:  m = 16'h00B8;  // 8,6,5,4
            9:  m = 16'h0110;  // 9,5
            10: m = 16'h0240;  // 10,7
            11: m = 16'h0500;  // 11,9
            12: m = 16'h0829;  // 12,6,4,1
            13: m = 16'h100D;  // 13,4,3,1
            14: m = 16'h2015;  // 14,5,3,1
            15: m = 16'h6000;  // 15,14
            default: m = 16'h0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/relock_lfsr.sv
module relock_lfsr
    import relock_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] SEED  = WIDTH'(8'hA5)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] value_o
);

    localparam logic [15:0]      TAP_ALL  = lfsr_taps(WIDTH);
    localparam logic [WIDTH-1:0] TAP_MASK = TAP_ALL[WIDTH-1:0];

    logic [WIDTH-1:0] sr_q;
    logic             fb;

    always_comb begin
        fb = ^(sr_q & TAP_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= SEED;
        end else begin
            sr_q <= {sr_q[WIDTH-2:0], fb};
        end
    end

    assign value_o = sr_q;

endmodule

// File: rtl/relock_window.sv
module relock_window #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [WIDTH-1:0] sample_i,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] period_o,
    output logic             match_o
);

    localparam logic [WIDTH-1:0] PERIOD_MIN = WIDTH'(1);
    localparam logic [WIDTH-1:0] CNT_ZERO   = '0;

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] per_q;
    logic [WIDTH-1:0] per_d;

    always_comb begin
        per_d = (sample_i == CNT_ZERO) ? PERIOD_MIN : sample_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ZERO;
            per_q <= CNT_ZERO;
        end else if (load_i) begin
            cnt_q <= CNT_ZERO;
            per_q <= per_d;
        end else if (run_i) begin
            cnt_q <= cnt_q + PERIOD_MIN;
        end
    end

    assign count_o  = cnt_q;
    assign period_o = per_q;
    assign match_o  = (cnt_q == per_q);

endmodule

// File: rtl/relock_fsm.sv
module relock_fsm
    import relock_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          auth_i,
    input  logic          match_i,
    output relock_state_e state_o,
    output logic          load_o,
    output logic          run_o,
    output logic          req_o
);

    relock_state_e st_q;
    relock_state_e st_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_POLL;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_POLL:  if (auth_i)  st_d = ST_TIME;
            ST_TIME:  if (match_i) st_d = ST_DRAIN;
            ST_DRAIN: if (!auth_i) st_d = ST_POLL;
            default:               st_d = ST_POLL;
        endcase
    end

    // Outputs
    always_comb begin
        load_o = 1'b0;
        run_o  = 1'b0;
        req_o  = 1'b0;
        unique case (st_q)
            ST_POLL: begin
                load_o = auth_i;
            end
            ST_TIME: begin
                run_o = !match_i;
                req_o = match_i;
            end
            ST_DRAIN: begin
            end
            default: begin
            end
        endcase
    end

    assign state_o = st_q;

endmodule

// File: rtl/relock_timer.sv
module relock_timer
    import relock_pkg::*;
#(
    parameter int                PRNG_W = 8,
    parameter int                IDX_W  = 3,
    parameter logic [PRNG_W-1:0] SEED   = PRNG_W'(8'hA5)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auth_i,
    output logic             relock_req_o,
    output logic [IDX_W-1:0] relock_idx_o
);

    logic [PRNG_W-1:0] lfsr_q;
    logic [PRNG_W-1:0] count_q;
    logic [PRNG_W-1:0] period_q;
    logic              win_match;
    logic              win_load;
    logic              win_run;
    logic              req;
    relock_state_e     state_q;

    relock_lfsr #(
        .WIDTH (PRNG_W),
        .SEED  (SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .value_o (lfsr_q)
    );

    relock_window #(
        .WIDTH (PRNG_W)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .load_i   (win_load),
        .run_i    (win_run),
        .sample_i (lfsr_q),
        .count_o  (count_q),
        .period_o (period_q),
        .match_o  (win_match)
    );

    relock_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .auth_i  (auth_i),
        .match_i (win_match),
        .state_o (state_q),
        .load_o  (win_load),
        .run_o   (win_run),
        .req_o   (req)
    );

    assign relock_req_o = req;
    assign relock_idx_o = req ? lfsr_q[IDX_W-1:0] : '0;

endmodule

// File: rtl/relock_timer_chk.sv
module relock_timer_chk
    import relock_pkg::*;
#(
    parameter int PRNG_W = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              auth_i,
    input logic              relock_req_o,
    input logic [IDX_W-1:0]  relock_idx_o,
    input logic [PRNG_W-1:0] lfsr_q,
    input logic [PRNG_W-1:0] count_q,
    input logic [PRNG_W-1:0] period_q,
    input relock_state_e     state_q
);

    a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POLL && auth_i) |=> (count_q == '0 && period_q == $past(lfsr_q)));

    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TIME && count_q != period_q) |=> (count_q == $past(count_q) + 1'b1));

    a_r5_idx_quiet: assert property (@(posedge clk) disable iff (rst)
        !relock_req_o |-> (relock_idx_o == '0));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        relock_req_o |=> (!relock_req_o && state_q == ST_DRAIN));

    a_r7_drain_silent: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && auth_i) |=> (state_q == ST_DRAIN && !relock_req_o));

endmodule

bind relock_timer relock_timer_chk #(
    .PRNG_W (PRNG_W),
    .IDX_W  (IDX_W)
) i_relock_timer_chk (
    .clk          (clk),
    .rst          (rst),
    .auth_i       (auth_i),
    .relock_req_o (relock_req_o),
    .relock_idx_o (relock_idx_o),
    .lfsr_q       (lfsr_q),
    .count_q      (count_q),
    .period_q     (period_q),
    .state_q      (state_q)
);

// File: tb/test_relock_timer.sv
module test_relock_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auth = 1'b0;
    logic       req;
    logic [2:0] idx;

    int checks = 0;
    int errors = 0;

    logic [7:0] mdl;  // independent model of the generator (R2)

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) begin
        if (rst) mdl <= 8'hA5;
        else     mdl <= {mdl[6:0], mdl[7] ^ mdl[5] ^ mdl[4] ^ mdl[3]};
    end

    relock_timer i_relock_timer (
        .clk          (clk),
        .rst          (rst),
        .auth_i       (auth),
        .relock_req_o (req),
        .relock_idx_o (idx)
    );

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst  = 1'b1;
        auth = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req == 1'b0, "R1 req in reset", int'(req), 0);
        check(idx == 3'd0, "R1 idx in reset", int'(idx), 0);
        rst = 1'b0;
    endtask

    // One authenticated window: measure distance to the request.
    task automatic t_window(input bit drop_early, input int hold, input int exp_lit);
        int         n;
        int         exp_p;
        bit         quiet_ok;
        logic [2:0] exp_idx;
        n        = 0;
        quiet_ok = 1'b1;
        @(negedge clk);
        auth  = 1'b1;
        exp_p = int'(mdl);
        @(posedge clk);  // capture edge (R3)
        while (n <= 300) begin
            @(negedge clk);
            if (drop_early && n == 0) auth = 1'b0;  // R8
            if (req) break;
            if (idx != 3'd0) quiet_ok = 1'b0;
            n++;
        end
        exp_idx = mdl[2:0];
        check(n == exp_p, drop_early ? "R8 window kept" : "R4 window length", n, exp_p);
        if (exp_lit >= 0) check(n == exp_lit, "R2 seeded sequence", n, exp_lit);
        check(quiet_ok, "R5 idx zero outside request", int'(quiet_ok), 1);
        check(idx == exp_idx, "R5 idx from low bits", int'(idx), int'(exp_idx));
        @(negedge clk);
        check(req == 1'b0, "R6 single-cycle request", int'(req), 0);
        if (hold > 0) begin
            bit silent;
            silent = 1'b1;
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                if (req) silent = 1'b0;
            end
            check(silent, "R7 auth ignored in DRAIN", int'(silent), 1);
        end
        auth = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_mid_window();
        bit silent;
        silent = 1'b1;
        @(negedge clk);
        auth = 1'b1;
        repeat (10) @(negedge clk);
        rst  = 1'b1;
        auth = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (req) silent = 1'b0;
        end
        check(silent, "R9 reset cancels request", int'(silent), 1);
    endtask

    initial begin
        t_reset();
        t_window(1'b0, 0, 74);       // R1/R2/R3/R4: first window after reset
        t_window(1'b0, 20, -1);      // R7: flag held high after request
        t_window(1'b0, 0, -1);       // R3: re-authentication
        t_window(1'b1, 0, -1);       // R8: flag falls during TIME
        t_window(1'b0, 5, -1);
        t_reset_mid_window();        // R9
        t_reset();
        t_window(1'b0, 0, 74);       // R1: seed reloaded
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule